// File: doc/BRIEF.md
# Address Translation Buffer with Hardware Table Walk

This block converts 32-bit virtual addresses into 30-bit physical addresses for 4 KB pages. It holds a small, fully associative set of recent translations. When a lookup finds the page, the physical address comes back in the same cycle as the request. When it does not, the block fetches one 32-bit page-table entry from memory on its own, installs it, and then retries the lookup. A missing page (an entry whose valid bit is clear) is reported as a page fault. This is kept separate from an ordinary buffer miss, which only costs a table read.

Requests and responses use a valid/ready pairing. A request is accepted in the cycle where `req_valid`, `req_ready` and `rsp_valid` are all high, and its response is the one presented in that cycle. Once `req_valid` is raised, the requester must hold it and keep `req_vaddr` and `req_write` stable until acceptance. `req_ready` follows `rsp_ready` whenever a response is presented, so a stalled consumer stalls the requester. The table fetch port also uses valid/ready for the address phase. Read data returns later as a single-cycle `mem_rd_data_valid` pulse, which the block always accepts. `ptbr` and `flush` are plain control pins. `ptbr` must stay constant while a walk is in progress.

Each buffered translation carries a written (dirty) flag, a used (reference) flag, and read and write permission bits. The response reports both flags as they stood before the access.

Top module: `tlb_xlate`

## Requirements
- R1: When idle with `req_valid` high and the page held in the buffer, `rsp_valid` rises in the same cycle with `rsp_hit`=1, and no table read is issued.
- R2: `rsp_paddr` bits 11..0 equal `req_vaddr` bits 11..0, and bits 29..12 hold the page's 18-bit physical page number. The virtual page number is `req_vaddr` bits 31..12.
- R3: On a miss, exactly one table read is issued, at byte address `ptbr` + (virtual page number × 4). Its address holds steady until `mem_rd_ready`.
- R4: The table entry layout is: bit 31 present, bit 30 dirty, bit 29 referenced, bit 28 write allowed, bit 27 read allowed, bits 17..0 physical page number. A present entry is installed with these flags. The request is then answered by the retried lookup with `rsp_hit`=0.
- R5: A fetched entry with bit 31 clear gives a response with `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0, and installs nothing. A repeat of the request walks again.
- R6: A permitted accepted access sets the entry's referenced flag, and a permitted write also sets its dirty flag. `rsp_dirty` and `rsp_ref` show the flags held before the access.
- R7: A write to a page without write permission, or a read from a page without read permission, responds with `rsp_prot`=1. The entry's flags and its replacement order are left unchanged.
- R8: A refill goes to the lowest-numbered empty slot. When all slots are full, it replaces the least recently used translation, where use means an install or a permitted accepted access.
- R9: `req_ready` stays low from the start of a table walk until the walk's outcome is presented.
- R10: A one-cycle `flush` pulse empties the whole buffer by the next cycle, so every later request walks. A response presented in the flush cycle completes normally.
- R11: While `rsp_valid` is high and `rsp_ready` is low, the response is held and the request is not accepted. This holds for hits and for page faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty the buffer |
| ptbr | input | 32 | Page-table base byte address |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 30 | Physical address |
| rsp_hit | output | 1 | Answered without a table walk |
| rsp_fault | output | 1 | Page not present |
| rsp_prot | output | 1 | Access type not permitted |
| rsp_dirty | output | 1 | Dirty flag before this access |
| rsp_ref | output | 1 | Referenced flag before this access |
| mem_rd_valid | output | 1 | Table read address present |
| mem_rd_ready | input | 1 | Memory takes the address |
| mem_rd_addr | output | 32 | Table entry byte address |
| mem_rd_data_valid | input | 1 | Table entry returned (one-cycle pulse) |
| mem_rd_data | input | 32 | Table entry |

## Verification
Flush and an accepted hit can meet in one edge. The hit wants to mark its entry used (and dirty on a write) and to reorder replacement, while the flush wants to drop every entry. The bench raises `flush` in the same cycle as a hit handshake, expects that response to be complete and correct, and expects the very next request to the same page to walk the table. Replacement ordering is driven by a reference model that randomly interleaves stalls, writes, protection faults and page faults over more pages than the buffer holds, and every walk or non-walk is compared against it.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 30;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  // table entry bit positions, decoded by the walker
  localparam int PTE_PRESENT = 31;
  localparam int PTE_DIRTY   = 30;
  localparam int PTE_REF     = 29;
  localparam int PTE_WR_OK   = 28;
  localparam int PTE_RD_OK   = 27;

  typedef struct packed {
    logic             dirty;
    logic             refd;
    logic             can_wr;
    logic             can_rd;
    logic [PPN_W-1:0] ppn;
  } tlb_ent_t;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_ADDR  = 2'd1,
    WK_DATA  = 2'd2,
    WK_FAULT = 2'd3
  } wk_state_t;
endpackage

// File: rtl/tlb_lru.sv
`timescale 1ns/1ps
module tlb_lru #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  input  logic [N-1:0]  vld_vec,
  output logic [IW-1:0] victim
);
  localparam logic [IW-1:0] OLDEST = IW'(N - 1);

  // age 0 = most recent; ages form a permutation of 0..N-1
  logic [IW-1:0] age_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)             age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < N; i++) begin
      if (!vld_vec[i] && !found) begin
        victim = IW'(i);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++) begin
        if (age_q[i] == OLDEST) victim = IW'(i);
      end
    end
  end

  AST_VICTIM_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (~vld_vec != '0) |-> !vld_vec[victim]); // R8
endmodule

// File: rtl/tlb_array.sv
`timescale 1ns/1ps
module tlb_array
  import tlb_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic [IW-1:0]    hit_idx,
  output tlb_ent_t         hit_ent,
  input  logic             upd_en,
  input  logic             upd_dirty,
  input  logic             ins_en,
  input  logic [IW-1:0]    ins_idx,
  input  logic [VPN_W-1:0] ins_vpn,
  input  tlb_ent_t         ins_ent,
  output logic [N-1:0]     vld_vec,
  output logic [N-1:0]     dirty_vec,
  output logic [N-1:0]     ref_vec
);
  logic [N-1:0]     vld_q;
  logic [VPN_W-1:0] tag_q [N];
  tlb_ent_t         ent_q [N];
  logic [N-1:0]     match;

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign match[g]     = vld_q[g] && (tag_q[g] == lk_vpn);
    assign dirty_vec[g] = ent_q[g].dirty;
    assign ref_vec[g]   = ent_q[g].refd;
  end

  assign vld_vec = vld_q;
  assign hit     = |match;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) hit_idx = IW'(i);
    end
  end

  assign hit_ent = ent_q[hit_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < N; i++) begin
        tag_q[i] <= '0;
        ent_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (flush)                              vld_q[i] <= 1'b0;
        else if (ins_en && ins_idx == IW'(i))  vld_q[i] <= 1'b1;
        if (ins_en && ins_idx == IW'(i)) begin
          tag_q[i] <= ins_vpn;
          ent_q[i] <= ins_ent;
        end else if (upd_en && hit_idx == IW'(i)) begin
          ent_q[i].refd <= 1'b1;
          if (upd_dirty) ent_q[i].dirty <= 1'b1;
        end
      end
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_vec == '0)); // R10
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R1
endmodule

// File: rtl/tlb_walker.sv
`timescale 1ns/1ps
module tlb_walker
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VPN_W-1:0] start_vpn,
  input  logic [VA_W-1:0]  ptbr,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [VA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_data_valid,
  input  logic [31:0]      mem_rd_data,
  input  logic             req_fire,
  input  logic             fault_ack,
  output logic             in_idle,
  output logic             fault_pend,
  output logic             walked,
  output logic             ins_en,
  output logic [VPN_W-1:0] ins_vpn,
  output tlb_ent_t         ins_ent
);
  wk_state_t        state_q;
  logic [VPN_W-1:0] vpn_q;
  logic             walked_q;
  logic             unused_pte_bits;

  assign in_idle      = (state_q == WK_IDLE);
  assign fault_pend   = (state_q == WK_FAULT);
  assign walked       = walked_q;
  assign mem_rd_valid = (state_q == WK_ADDR);
  assign mem_rd_addr  = ptbr + VA_W'({vpn_q, 2'b00});
  assign ins_en       = (state_q == WK_DATA) && mem_rd_data_valid && mem_rd_data[PTE_PRESENT];
  assign ins_vpn      = vpn_q;
  assign ins_ent      = '{dirty:  mem_rd_data[PTE_DIRTY],
                          refd:   mem_rd_data[PTE_REF],
                          can_wr: mem_rd_data[PTE_WR_OK],
                          can_rd: mem_rd_data[PTE_RD_OK],
                          ppn:    mem_rd_data[PPN_W-1:0]};
  assign unused_pte_bits = ^mem_rd_data[PTE_RD_OK-1:PPN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WK_IDLE;
      vpn_q    <= '0;
      walked_q <= 1'b0;
    end else begin
      if (ins_en)        walked_q <= 1'b1;
      else if (req_fire) walked_q <= 1'b0;
      unique case (state_q)
        WK_IDLE: if (start) begin
          state_q <= WK_ADDR;
          vpn_q   <= start_vpn;
        end
        WK_ADDR: if (mem_rd_ready) state_q <= WK_DATA;
        WK_DATA: if (mem_rd_data_valid)
          state_q <= mem_rd_data[PTE_PRESENT] ? WK_IDLE : WK_FAULT;
        WK_FAULT: if (fault_ack) state_q <= WK_IDLE;
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R3
  AST_ABSENT_TO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WK_DATA) && mem_rd_data_valid && !mem_rd_data[PTE_PRESENT] |=> fault_pend); // R5
endmodule

// File: rtl/tlb_xlate.sv
`timescale 1ns/1ps
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic [31:0] ptbr,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [29:0] rsp_paddr,
  output logic        rsp_hit,
  output logic        rsp_fault,
  output logic        rsp_prot,
  output logic        rsp_dirty,
  output logic        rsp_ref,
  output logic        mem_rd_valid,
  input  logic        mem_rd_ready,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_data_valid,
  input  logic [31:0] mem_rd_data
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0] req_vpn;
  logic             hit, allowed, lk_ok, start, req_fire, upd_en;
  logic [IW-1:0]    hit_idx, victim, touch_idx;
  tlb_ent_t         hit_ent, ins_ent;
  logic             in_idle, fault_pend, walked, ins_en;
  logic [VPN_W-1:0] ins_vpn;
  logic [ENTRIES-1:0] vld_vec, dirty_vec, ref_vec;

  assign req_vpn   = req_vaddr[VA_W-1:OFF_W];
  assign allowed   = req_write ? hit_ent.can_wr : hit_ent.can_rd;
  assign lk_ok     = in_idle && req_valid && hit;
  assign start     = in_idle && req_valid && !hit;

  assign rsp_valid = lk_ok || fault_pend;
  assign rsp_hit   = lk_ok && !walked;
  assign rsp_fault = fault_pend;
  assign rsp_prot  = lk_ok && !allowed;
  assign rsp_dirty = lk_ok && hit_ent.dirty;
  assign rsp_ref   = lk_ok && hit_ent.refd;
  assign rsp_paddr = lk_ok ? {hit_ent.ppn, req_vaddr[OFF_W-1:0]} : '0;

  assign req_ready = rsp_valid && rsp_ready;
  assign req_fire  = req_valid && req_ready;
  assign upd_en    = req_fire && lk_ok && allowed;
  assign touch_idx = ins_en ? victim : hit_idx;

  tlb_array #(.N(ENTRIES), .IW(IW)) i_array (
    .clk, .rst_n, .flush,
    .lk_vpn    (req_vpn),
    .hit, .hit_idx, .hit_ent,
    .upd_en,
    .upd_dirty (req_write),
    .ins_en,
    .ins_idx   (victim),
    .ins_vpn, .ins_ent,
    .vld_vec, .dirty_vec, .ref_vec
  );

  tlb_lru #(.N(ENTRIES), .IW(IW)) i_lru (
    .clk, .rst_n,
    .touch_en  (upd_en || ins_en),
    .touch_idx,
    .vld_vec,
    .victim
  );

  tlb_walker i_walker (
    .clk, .rst_n, .start,
    .start_vpn (req_vpn),
    .ptbr,
    .mem_rd_valid, .mem_rd_ready, .mem_rd_addr,
    .mem_rd_data_valid, .mem_rd_data,
    .req_fire,
    .fault_ack (rsp_ready),
    .in_idle, .fault_pend, .walked,
    .ins_en, .ins_vpn, .ins_ent
  );

  AST_NO_ACCEPT_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready); // R9
  AST_RETRY_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en && !flush |=> rsp_valid && !rsp_hit && !rsp_fault); // R4
  AST_FAULT_KEEPS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault && !flush |=> $stable(vld_vec)); // R5
  AST_PROT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_prot |=> $stable(dirty_vec) && $stable(ref_vec)); // R7
  AST_WRITE_MARKS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && lk_ok && !rsp_prot && req_write |=> dirty_vec[$past(hit_idx)]); // R6
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready && !flush |=> rsp_valid); // R11
endmodule

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;
  localparam int N = 16;
  localparam logic [31:0] PTBR = 32'h0008_0000;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic [31:0] ptbr = PTBR;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [31:0] req_vaddr = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_fault, rsp_prot, rsp_dirty, rsp_ref;
  logic [29:0] rsp_paddr;
  logic mem_rd_valid, mem_rd_ready = 1'b0, mem_rd_data_valid = 1'b0;
  logic [31:0] mem_rd_addr, mem_rd_data = '0;

  always #5 clk = ~clk;

  tlb_xlate #(.ENTRIES(N)) i_tlb_xlate (
    .clk, .rst_n, .flush, .ptbr,
    .req_valid, .req_ready, .req_vaddr, .req_write,
    .rsp_valid, .rsp_ready, .rsp_paddr, .rsp_hit, .rsp_fault, .rsp_prot,
    .rsp_dirty, .rsp_ref,
    .mem_rd_valid, .mem_rd_ready, .mem_rd_addr, .mem_rd_data_valid, .mem_rd_data
  );

  int n_chk = 0, n_err = 0, walk_cnt = 0;
  logic [19:0] cur_vpn = '0;
  logic [31:0] pt [64];
  logic [31:0] pt_top = '0;

  // reference model of the buffer
  bit m_v [N]; logic [19:0] m_tag [N]; bit m_d [N], m_r [N], m_cw [N], m_cr [N];
  logic [17:0] m_ppn [N]; int m_age [N];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_pte(bit p, bit d, bit r, bit cw, bit cr, logic [17:0] ppn);
    return {p, d, r, cw, cr, 9'd0, ppn};
  endfunction

  function automatic logic [31:0] pte_of(logic [19:0] v);
    if (v < 20'd64) return pt[v[5:0]];
    if (v == 20'hFFFFF) return pt_top;
    return 32'd0;
  endfunction

  function automatic int m_find(logic [19:0] v);
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == v) return i;
    return -1;
  endfunction

  function automatic void m_touch(int k);
    int old;
    old = m_age[k];
    for (int j = 0; j < N; j++) if (j != k && m_age[j] < old) m_age[j]++;
    m_age[k] = 0;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    for (int i = 0; i < N; i++) if (m_age[i] == N - 1) return i;
    return 0;
  endfunction

  function automatic void m_flush();
    for (int i = 0; i < N; i++) m_v[i] = 0;
  endfunction

  task automatic do_req(input logic [19:0] vpn, input logic [11:0] off, input bit wr,
                        input int stall, input bit fl);
    int k, w0;
    bit walk_exp, flt_exp, prot_exp, ed, er;
    logic [31:0] pte;
    logic [29:0] epa;
    k = m_find(vpn); walk_exp = (k < 0); pte = pte_of(vpn);
    flt_exp = 0; prot_exp = 0; ed = 0; er = 0; epa = '0;
    if (walk_exp) begin
      if (!pte[31]) flt_exp = 1;
      else begin
        k = m_victim();
        m_v[k] = 1; m_tag[k] = vpn; m_d[k] = pte[30]; m_r[k] = pte[29];
        m_cw[k] = pte[28]; m_cr[k] = pte[27]; m_ppn[k] = pte[17:0];
        m_touch(k);
      end
    end
    if (!flt_exp) begin
      prot_exp = wr ? !m_cw[k] : !m_cr[k];
      ed = m_d[k]; er = m_r[k]; epa = {m_ppn[k], off};
    end
    @(negedge clk);
    cur_vpn = vpn; w0 = walk_cnt;
    req_vaddr = {vpn, off}; req_write = wr; req_valid = 1'b1; rsp_ready = (stall == 0);
    #1;
    while (!rsp_valid) begin @(negedge clk); #1; end
    if (stall > 0) begin
      chk(!req_ready, "R11 accepted while consumer stalls", 32'(req_ready), 32'd0);
      repeat (stall) begin
        @(negedge clk); #1;
        chk(rsp_valid, "R11 response dropped during stall", 32'(rsp_valid), 32'd1);
      end
      rsp_ready = 1'b1; #1;
    end
    chk(rsp_fault == flt_exp, "R5 fault flag", 32'(rsp_fault), 32'(flt_exp));
    chk(rsp_hit == (!walk_exp && !flt_exp), "R1/R4 hit flag", 32'(rsp_hit), 32'(!walk_exp && !flt_exp));
    chk(rsp_prot == prot_exp, "R7 protection flag", 32'(rsp_prot), 32'(prot_exp));
    chk(rsp_paddr == epa, "R2 physical address", {2'b0, rsp_paddr}, {2'b0, epa});
    chk(rsp_dirty == ed && rsp_ref == er, "R6 dirty/ref report",
        {30'd0, rsp_dirty, rsp_ref}, {30'd0, ed, er});
    chk(req_ready, "R11 accept with consumer ready", 32'(req_ready), 32'd1);
    if (fl) flush = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0; flush = 1'b0;
    chk((walk_cnt != w0) == walk_exp, "R3/R8 walk occurrence", 32'(walk_cnt != w0), 32'(walk_exp));
    if (!flt_exp && !prot_exp) begin
      m_r[k] = 1;
      if (wr) m_d[k] = 1;
      m_touch(k);
    end
    if (fl) m_flush();
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    m_flush();
  endtask

  // table memory responder
  initial begin
    forever begin
      @(negedge clk); #1;
      if (mem_rd_valid) begin
        logic [19:0] v;
        int d;
        chk(mem_rd_addr == PTBR + {10'd0, cur_vpn, 2'b00}, "R3 table address",
            mem_rd_addr, PTBR + {10'd0, cur_vpn, 2'b00});
        v = 20'((mem_rd_addr - PTBR) >> 2);
        d = int'($urandom % 3);
        repeat (d) begin
          @(negedge clk); #1;
          chk(!req_ready && mem_rd_valid, "R9 ready during walk / R3 address held",
              {30'd0, req_ready, mem_rd_valid}, 32'd1);
        end
        mem_rd_ready = 1'b1;
        @(posedge clk); #1;
        mem_rd_ready = 1'b0;
        d = int'($urandom % 3);
        repeat (d) begin
          @(negedge clk); #1;
          chk(!req_ready, "R9 ready during walk", 32'(req_ready), 32'd0);
        end
        @(negedge clk);
        mem_rd_data = pte_of(v); mem_rd_data_valid = 1'b1; walk_cnt++;
        @(negedge clk);
        mem_rd_data_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_age[i] = i; end
    for (int i = 0; i < 64; i++)
      pt[i] = mk_pte(($urandom % 8) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
                     ($urandom % 4) != 0, 18'($urandom));
    pt[40] = mk_pte(1, 0, 0, 1, 1, 18'h2AAAA);
    pt[41] = mk_pte(1, 0, 0, 0, 1, 18'h01234);
    pt[42] = mk_pte(1, 0, 0, 1, 0, 18'h3FFFF);
    pt[43] = mk_pte(0, 1, 1, 1, 1, 18'h00055);
    for (int i = 44; i <= 60; i++) pt[i] = mk_pte(1, 0, 0, 1, 1, 18'(i * 3));
    pt_top = mk_pte(1, 1, 0, 1, 1, 18'h00001);

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!rsp_valid && !req_ready && !mem_rd_valid, "reset state (R9)",
        {29'd0, rsp_valid, req_ready, mem_rd_valid}, 32'd0);

    do_req(20'd40, 12'h123, 0, 0, 0);   // R4 refill then retry
    do_req(20'd40, 12'hFFF, 0, 0, 0);   // R1 hit, ref now set
    do_req(20'd40, 12'h000, 1, 0, 0);   // R6 write marks dirty
    do_req(20'd40, 12'h456, 0, 0, 0);   // R6 dirty now reported
    do_req(20'd41, 12'h010, 1, 0, 0);   // R7 write to read-only
    do_req(20'd41, 12'h020, 0, 0, 0);   // R7 flags untouched
    do_req(20'd42, 12'h030, 0, 0, 0);   // R7 read from write-only
    do_req(20'd43, 12'h040, 0, 0, 0);   // R5 page fault
    do_req(20'd43, 12'h040, 1, 2, 0);   // R5 walks again, R11 stalled fault
    do_req(20'hFFFFF, 12'hABC, 0, 0, 0); // R3 top page address
    do_req(20'd40, 12'h777, 0, 3, 0);   // R11 stalled hit
    do_req(20'd40, 12'h001, 1, 0, 1);   // R10 flush with hit handshake
    do_req(20'd40, 12'h002, 0, 0, 0);   // R10 must walk again

    do_flush();                          // R8 replacement order
    for (int i = 44; i <= 59; i++) do_req(20'(i), 12'(i), 0, 0, 0);
    do_req(20'd44, 12'h0, 0, 0, 0);
    do_req(20'd60, 12'h0, 0, 0, 0);     // evicts 45
    do_req(20'd44, 12'h0, 0, 0, 0);
    do_req(20'd45, 12'h0, 0, 0, 0);

    for (int n = 0; n < 300; n++) begin
      int st;
      st = (($urandom % 4) == 0) ? int'(1 + $urandom % 2) : 0;
      if (($urandom % 50) == 0) do_flush();
      do_req(20'($urandom % 24), 12'($urandom), $urandom % 2, st, ($urandom % 40) == 0);
    end

    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule